// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block follows the bus from the side of a single disk target. It watches the BSY, SEL, ATN and ACK levels and the byte that the initiator places on the data bus. It moves through arbitration, selection, an optional message-out exchange and command collection. It then runs a data-out or data-in transfer, returns a status byte and a message-in byte, and releases the bus. The six information phases carry a 3-bit phase code. Bus free, arbitration and the two selection sub-states are internal and report no valid phase.

A command executor sits beside the sequencer. Before the last command byte arrives, it presents the transfer length, the transfer direction and the status byte. It can read any collected command byte by index. During data-in it supplies the byte for the current offset, and during data-out it receives each accepted byte as a one-cycle strobe. The length of the command comes from the group field in the top bits of the opcode. The length of an incoming message comes from the value of its first byte. An identify message places a logical unit number into the collected command.

Top module: `scsi_target_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in bus free with `bsy_o`, `req_o`, `phase_valid_o`, `offset_o` and `data_o` all zero.
- R2: In bus free, BSY high with SEL low and `drive_i` low starts arbitration only when exactly one bit of `data_i` is set. That bit's index becomes the initiator ID. Any other mask leaves the block in bus free. While arbitrating, `data_o` echoes `data_i`; in bus free, `data_o` is 0.
- R3: In bus free, SEL high with BSY low starts selection only when `data_i` is nonzero and has at most two bits set. Other masks are ignored, and `bsy_o` stays low.
- R4: In selection, once BSY is low, the target becomes the highest ID that is set in the mask, has a device present and is not the arbitrating initiator. `bsy_o` then rises and stays high through every information phase. If no ID matches and SEL is low, the block returns to bus free.
- R5: After the target is chosen, SEL going low enters message out (code 6) if ATN was high during selection, and command (code 2) otherwise. REQ is asserted.
- R6: Opcode bits 7:5 select the command length: 0→6, 1→10, 2→10, 3→12, 4→16, 5→12, 6→10, 7→6 bytes.
- R7: A message whose first byte is 0x00, 0x02–0x1F or 0x80–0xFF is one byte long. A first byte of 0x20–0x2F gives two bytes. Any other first byte is an extended message whose total length is the second byte, with a minimum of two bytes. A complete message leads to command.
- R8: A message with bit 7 set and bit 5 clear records bits 2:0 as the LUN. After the command is collected, that LUN replaces bits 7:5 of command byte 1, which is read back through `cmd_idx_i`/`cmd_byte_o`.
- R9: After the last command byte, the next phase is data out (0) if `xfer_write_i` is high and `xfer_len_i` is nonzero. Otherwise it is data in (1) when `status_i` is 0 and the length is nonzero. In all other cases it is status (3).
- R10: `req_o` is low while ACK is high. In a write phase (code bit 0 = 0), a byte is taken on an ACK rising edge only when `drive_i` is high. An ACK edge with `drive_i` low changes nothing.
- R11: Each data-out byte is shown on `wr_data_o` with a one-cycle `wr_valid_o`. Data in presents `rd_data_i`, which belongs to the current `offset_o`. Both move to status after the latched length is reached.
- R12: Status shows `status_i`. An ACK moves to message in (code 7), which shows 0x00. The next ACK releases the bus with `bsy_o` low.
- R13: `offset_o` is 16 bits, counts bytes within a phase and is 0 on every phase entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsy_i | input | 1 | BSY level from the bus |
| sel_i | input | 1 | SEL level |
| atn_i | input | 1 | ATN level |
| ack_i | input | 1 | ACK level |
| drive_i | input | 1 | Initiator is driving the data bus |
| data_i | input | 8 | Data bus byte from the initiator |
| dev_present_i | input | 8 | One bit per ID with a device present |
| xfer_len_i | input | OFFW | Data length for the command |
| xfer_write_i | input | 1 | Command writes data to the target |
| status_i | input | 8 | Status byte from the executor |
| rd_data_i | input | 8 | Data-in byte for the current offset |
| cmd_idx_i | input | log2(CMDMAX) | Command byte index to read |
| phase_o | output | 3 | Information phase code |
| phase_valid_o | output | 1 | An information phase is active |
| bsy_o | output | 1 | Target BSY |
| req_o | output | 1 | Target REQ |
| data_o | output | 8 | Byte for the initiator to read |
| target_id_o | output | 3 | Selected target ID |
| offset_o | output | OFFW | Byte offset in the current phase |
| cmd_byte_o | output | 8 | Command byte at `cmd_idx_i` |
| cmd_done_o | output | 1 | One-cycle pulse when the command is complete |
| wr_valid_o | output | 1 | Data-out byte strobe |
| wr_data_o | output | 8 | Data-out byte |

## Verification
The bench builds the block with its defaults: OFFW of 16 and CMDMAX of 16. This means every opcode group, including the 16-byte one, fits in the command store. The offset cannot wrap for the short transfers used. Random opcodes therefore cover all eight length groups. Random message kinds cover identify, non-identify one-byte, two-byte and extended messages, including extended length values below two. The random direction, length and status combinations reach each of the three post-command branches, including write with zero length.

// File: rtl/scsi_target_seq.sv
module scsi_target_seq #(
  parameter int OFFW   = 16,
  parameter int CMDMAX = 16,
  localparam int CIW   = $clog2(CMDMAX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bsy_i,
  input  logic            sel_i,
  input  logic            atn_i,
  input  logic            ack_i,
  input  logic            drive_i,
  input  logic [7:0]      data_i,
  input  logic [7:0]      dev_present_i,
  input  logic [OFFW-1:0] xfer_len_i,
  input  logic            xfer_write_i,
  input  logic [7:0]      status_i,
  input  logic [7:0]      rd_data_i,
  input  logic [CIW-1:0]  cmd_idx_i,
  output logic [2:0]      phase_o,
  output logic            phase_valid_o,
  output logic            bsy_o,
  output logic            req_o,
  output logic [7:0]      data_o,
  output logic [2:0]      target_id_o,
  output logic [OFFW-1:0] offset_o,
  output logic [7:0]      cmd_byte_o,
  output logic            cmd_done_o,
  output logic            wr_valid_o,
  output logic [7:0]      wr_data_o
);

  typedef enum logic [3:0] {
    S_FREE, S_ARB, S_SEL1, S_SEL2, S_MSGO, S_CMD, S_DOUT, S_DIN, S_STAT, S_MSGI
  } state_t;

  state_t          st, nxt_cmd;
  logic [OFFW-1:0] off, mcnt, xlen;
  logic            bsy_q, ack_q, init_v, atn_l, lun_v;
  logic [2:0]      init_id, tgt, lun, arb_idx, hit_id;
  logic            hit;
  logic [7:0]      msg0, msg1, m0, m1, mlen, c0;
  logic [4:0]      clen;
  logic [7:0]      cmd_q [CMDMAX];
  logic            cmd_done_q, wr_v_q;
  logic [7:0]      wr_d_q;

  wire ack_rise = ack_i & ~ack_q;
  wire wr_ok    = ack_rise & drive_i;

  assign mcnt = off + 1'b1;
  assign m0   = (off == '0) ? data_i : msg0;
  assign m1   = (off == OFFW'(1)) ? data_i : msg1;
  assign c0   = (off == '0) ? data_i : cmd_q[0];

  always_comb begin
    arb_idx = '0;
    for (int i = 0; i < 8; i++)
      if (data_i[i]) arb_idx = 3'(i);
  end

  always_comb begin
    hit = 1'b0;
    hit_id = '0;
    for (int i = 0; i < 8; i++)
      if (data_i[i] && dev_present_i[i] && !(init_v && init_id == 3'(i))) begin
        hit = 1'b1;
        hit_id = 3'(i);
      end
  end

  always_comb begin
    if (m0 == 8'h00 || (m0 >= 8'h02 && m0 <= 8'h1f) || m0 >= 8'h80) mlen = 8'd1;
    else if (m0 >= 8'h20 && m0 <= 8'h2f)                               mlen = 8'd2;
    else if (mcnt < OFFW'(2))                                          mlen = 8'd3;
    else                                                               mlen = m1;
  end

  always_comb begin
    case (c0[7:5])
      3'd0, 3'd7:       clen = 5'd6;
      3'd1, 3'd2, 3'd6: clen = 5'd10;
      3'd3, 3'd5:       clen = 5'd12;
      default:          clen = 5'd16;
    endcase
  end

  always_comb begin
    if (xfer_write_i && xfer_len_i != '0)         nxt_cmd = S_DOUT;
    else if (status_i == 8'h00 && xfer_len_i != '0) nxt_cmd = S_DIN;
    else                                          nxt_cmd = S_STAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FREE;  off <= '0;  xlen <= '0;
      bsy_q <= 1'b0; ack_q <= 1'b0; init_v <= 1'b0; init_id <= '0;
      tgt <= '0;     atn_l <= 1'b0; lun_v <= 1'b0;  lun <= '0;
      msg0 <= '0;    msg1 <= '0;
      cmd_done_q <= 1'b0; wr_v_q <= 1'b0; wr_d_q <= '0;
    end else begin
      ack_q <= ack_i;
      cmd_done_q <= 1'b0;
      wr_v_q <= 1'b0;
      case (st)
        S_FREE: begin
          bsy_q <= 1'b0;
          if (bsy_i && !sel_i && !drive_i) begin
            if ($countones(data_i) == 1) begin
              st <= S_ARB; init_v <= 1'b1; init_id <= arb_idx;
            end
          end else if (!bsy_i && sel_i && data_i != 8'h00 && $countones(data_i) <= 2) begin
            st <= S_SEL1; init_v <= 1'b0;
          end
        end
        S_ARB: if (bsy_i && sel_i) st <= S_SEL1;
        S_SEL1: begin
          atn_l <= atn_i;
          lun_v <= 1'b0;
          if (!bsy_i) begin
            if (hit) begin
              tgt <= hit_id; bsy_q <= 1'b1; st <= S_SEL2;
            end else if (!sel_i) st <= S_FREE;
          end
        end
        S_SEL2: if (!sel_i) begin
          st <= atn_l ? S_MSGO : S_CMD;
          off <= '0;
        end
        S_MSGO: if (wr_ok) begin
          if (off == '0)       msg0 <= data_i;
          if (off == OFFW'(1)) msg1 <= data_i;
          off <= mcnt;
          if (mcnt >= OFFW'(mlen)) begin
            if ((m0 & 8'ha0) == 8'h80) begin
              lun_v <= 1'b1; lun <= m0[2:0];
            end
            st <= S_CMD; off <= '0;
          end
        end
        S_CMD: if (wr_ok) begin
          off <= mcnt;
          if (mcnt >= OFFW'(clen)) begin
            cmd_done_q <= 1'b1; xlen <= xfer_len_i; st <= nxt_cmd; off <= '0;
          end
        end
        S_DOUT: if (wr_ok) begin
          wr_v_q <= 1'b1; wr_d_q <= data_i; off <= mcnt;
          if (mcnt >= xlen) begin st <= S_STAT; off <= '0; end
        end
        S_DIN: if (ack_rise) begin
          off <= mcnt;
          if (mcnt >= xlen) begin st <= S_STAT; off <= '0; end
        end
        S_STAT: if (ack_rise) begin st <= S_MSGI; off <= '0; end
        S_MSGI: if (ack_rise) begin st <= S_FREE; bsy_q <= 1'b0; off <= '0; end
        default: st <= S_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && st == S_CMD && wr_ok) begin
      if (off < OFFW'(CMDMAX)) cmd_q[off[CIW-1:0]] <= data_i;
      if (mcnt >= OFFW'(clen) && lun_v) cmd_q[1] <= {lun, cmd_q[1][4:0]};
    end
  end

  always_comb begin
    phase_valid_o = 1'b1;
    case (st)
      S_DOUT:  phase_o = 3'd0;
      S_DIN:   phase_o = 3'd1;
      S_CMD:   phase_o = 3'd2;
      S_STAT:  phase_o = 3'd3;
      S_MSGO:  phase_o = 3'd6;
      S_MSGI:  phase_o = 3'd7;
      default: begin phase_o = 3'd0; phase_valid_o = 1'b0; end
    endcase
  end

  always_comb begin
    case (st)
      S_ARB:   data_o = data_i;
      S_DIN:   data_o = rd_data_i;
      S_STAT:  data_o = status_i;
      default: data_o = 8'h00;
    endcase
  end

  assign req_o       = phase_valid_o & ~ack_i;
  assign bsy_o       = bsy_q;
  assign target_id_o = tgt;
  assign offset_o    = off;
  assign cmd_byte_o  = cmd_q[cmd_idx_i];
  assign cmd_done_o  = cmd_done_q;
  assign wr_valid_o  = wr_v_q;
  assign wr_data_o   = wr_d_q;

  assert_bsy_info_R4: assert property (@(posedge clk) disable iff (rst)
    phase_valid_o |-> bsy_o);

  assert_off_clear_R13: assert property (@(posedge clk) disable iff (rst)
    (phase_valid_o && $past(phase_valid_o) && phase_o != $past(phase_o)) |-> offset_o == '0);

  assert_cmd_next_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_done_o |-> (phase_valid_o && (phase_o == 3'd0 || phase_o == 3'd1 || phase_o == 3'd3)));

  assert_msgi_free_R12: assert property (@(posedge clk) disable iff (rst)
    (phase_valid_o && phase_o == 3'd7 && ack_rise) |=> (!bsy_o && !phase_valid_o));

  assert_wr_dout_R11: assert property (@(posedge clk) disable iff (rst)
    !(phase_valid_o && phase_o == 3'd0) |=> !wr_valid_o);

endmodule

// File: tb/sim_scsi_target_seq.sv
module sim_scsi_target_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic bsy, sel, atn, ack, drv, xwr;
  logic [7:0] dat, dev, stat, rd;
  logic [15:0] xlen;
  logic [3:0] cidx;
  logic [2:0] phase, tid;
  logic pv, bsy_o, req, cdone, wv;
  logic [7:0] dout, cbyte, wd;
  logic [15:0] offs;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rdf(input int i);
    return 8'(i * 3 + 8'h11);
  endfunction
  assign rd = rdf(int'(offs));

  scsi_target_seq u0 (
    .clk(clk), .rst(rst), .bsy_i(bsy), .sel_i(sel), .atn_i(atn), .ack_i(ack),
    .drive_i(drv), .data_i(dat), .dev_present_i(dev), .xfer_len_i(xlen),
    .xfer_write_i(xwr), .status_i(stat), .rd_data_i(rd), .cmd_idx_i(cidx),
    .phase_o(phase), .phase_valid_o(pv), .bsy_o(bsy_o), .req_o(req), .data_o(dout),
    .target_id_o(tid), .offset_o(offs), .cmd_byte_o(cbyte), .cmd_done_o(cdone),
    .wr_valid_o(wv), .wr_data_o(wd));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int cmdlen(input logic [7:0] op);
    case (op[7:5])
      3'd0, 3'd7: return 6;
      3'd1, 3'd2, 3'd6: return 10;
      3'd3, 3'd5: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_next(input bit w, input int len, input logic [7:0] s);
    if (w && len != 0) return 0;
    if (s == 8'h00 && len != 0) return 1;
    return 3;
  endfunction

  task automatic send(input logic [7:0] b);
    dat = b; drv = 1; ack = 1; tick();
    chk("R10 req low under ack", int'(req), 0);
    ack = 0; tick();
  endtask

  task automatic rack();
    drv = 0; ack = 1; tick();
    ack = 0; tick();
  endtask

  task automatic sel_free(input logic [7:0] mask, input int etgt, input bit a);
    dat = mask; sel = 1; bsy = 0; atn = a; drv = 1; tick();
    tick();
    chk("R4 bsy asserted", int'(bsy_o), 1);
    chk("R4 target id", int'(tid), etgt);
    sel = 0; tick();
    atn = 0;
    chk("R5 phase after select", int'(phase), a ? 6 : 2);
    chk("R5 req", int'(req), 1);
  endtask

  task automatic body(input bit a, input int mk, input int mp, input logic [2:0] lun,
                      input logic [7:0] op, input bit w, input int len, input logic [7:0] s);
    logic [7:0] mb [8];
    logic [7:0] cb [16];
    int nm, n, en;
    xlen = 16'(len); xwr = w; stat = s;
    if (a) begin
      for (int j = 0; j < 8; j++) mb[j] = 8'($urandom);
      case (mk)
        0: begin nm = 1; mb[0] = 8'h80 | (mp[0] ? 8'h40 : 8'h00) | {5'd0, lun}; end
        1: begin nm = 2; mb[0] = 8'h20 | 8'(mp[3:0]); end
        2: begin n = mp % 6; mb[0] = 8'h01; mb[1] = 8'(n); nm = (n < 2) ? 2 : n; end
        default: begin nm = 1; mb[0] = 8'ha0 | {5'd0, lun}; end
      endcase
      for (int j = 0; j < nm; j++) begin
        send(mb[j]);
        if (j == nm - 2) chk("R7 message not done early", int'(phase), 6);
      end
      chk("R7 message ends in command", int'(phase), 2);
      chk("R13 offset on command entry", int'(offs), 0);
    end
    n = cmdlen(op);
    cb[0] = op;
    for (int j = 1; j < 16; j++) cb[j] = 8'($urandom);
    for (int j = 0; j < n; j++) begin
      send(cb[j]);
      if (j == n - 2) chk("R6 command not done early", int'(phase), 2);
    end
    en = exp_next(w, len, s);
    chk("R9 phase after command", int'(phase), en);
    chk("R13 offset on data entry", int'(offs), 0);
    cidx = 4'd1;
    #1;
    chk("R8 command byte 1", int'(cbyte),
        (a && mk == 0) ? int'({lun, cb[1][4:0]}) : int'(cb[1]));
    if (en == 0) begin
      for (int j = 0; j < len; j++) begin
        logic [7:0] b;
        b = 8'($urandom);
        dat = b; drv = 1; ack = 1; tick();
        chk("R11 write strobe", int'(wv), 1);
        chk("R11 write data", int'(wd), int'(b));
        ack = 0; tick();
      end
    end else if (en == 1) begin
      for (int j = 0; j < len; j++) begin
        chk("R11 read data", int'(dout), int'(rdf(j)));
        rack();
      end
    end
    chk("R11 status phase", int'(phase), 3);
    chk("R12 status byte", int'(dout), int'(s));
    rack();
    chk("R12 message in phase", int'(phase), 7);
    chk("R12 message byte", int'(dout), 0);
    rack();
    chk("R12 bus released", int'(pv), 0);
    chk("R12 bsy dropped", int'(bsy_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] tl [3];
    void'($urandom(32'd2024));
    tl[0] = 3'd1; tl[1] = 3'd2; tl[2] = 3'd5;
    bsy = 0; sel = 0; atn = 0; ack = 0; drv = 0; dat = 0;
    dev = 8'b1010_0110; xlen = 0; xwr = 0; stat = 0; cidx = 0;
    repeat (3) tick();
    rst = 0; tick();
    chk("R1 phase valid", int'(pv), 0);
    chk("R1 bsy", int'(bsy_o), 0);
    chk("R1 req", int'(req), 0);
    chk("R1 offset", int'(offs), 0);
    chk("R1 data", int'(dout), 0);

    bsy = 1; drv = 0; dat = 8'h03; tick();
    chk("R2 bad arbitration mask ignored", int'(dout), 0);
    dat = 8'h80; tick();
    chk("R2 arbitration echo", int'(dout), 8'h80);
    sel = 1; tick();
    dat = 8'h84; bsy = 0; drv = 1; tick();
    chk("R4 initiator excluded", int'(tid), 2);
    chk("R4 bsy after arbitration", int'(bsy_o), 1);
    sel = 0; tick();
    chk("R5 command without atn", int'(phase), 2);
    dat = 8'h55; drv = 0; ack = 1; tick(); ack = 0; tick();
    chk("R10 undriven byte ignored", int'(offs), 0);
    body(0, 0, 0, 0, 8'h00, 0, 0, 8'h00);

    bsy = 0; sel = 1; drv = 1; dat = 8'h26; tick(); tick();
    chk("R3 three-bit mask rejected", int'(bsy_o), 0);
    dat = 8'h00; tick(); tick();
    chk("R3 zero mask rejected", int'(bsy_o), 0);
    sel = 0; tick();

    dat = 8'h01; sel = 1; tick(); tick();
    chk("R4 no device no bsy", int'(bsy_o), 0);
    sel = 0; tick();
    chk("R4 back to free", int'(pv), 0);
    sel_free(8'h24, 5, 1);
    body(1, 0, 1, 3'd6, 8'h28, 0, 3, 8'h00);
    sel_free(8'h06, 2, 1);
    body(1, 2, 0, 3'd1, 8'h8a, 1, 0, 8'h00);
    sel_free(8'h02, 1, 1);
    body(1, 3, 0, 3'd3, 8'h2a, 0, 2, 8'h02);

    for (int t = 0; t < 40; t++) begin
      int k; bit a; logic [7:0] m;
      k = int'($urandom % 3);
      m = 8'(1 << tl[k]);
      if ($urandom % 2 == 1) m = m | 8'h01;
      a = 1'($urandom % 2);
      sel_free(m, int'(tl[k]), a);
      body(a, int'($urandom % 4), int'($urandom % 64), 3'($urandom), 8'($urandom),
           1'($urandom % 2), int'($urandom % 5), ($urandom % 3 == 0) ? 8'h02 : 8'h00);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule